// File: doc/BRIEF.md
# Destination Flow-Control Credit Counters

This block keeps the four counters that a channel destination uses to track flow control. The first counts the READY indications the host has issued. The second counts bursts that have completed. The third counts the receive buffers the host has made available. The fourth counts completed bursts that closed a packet. From these counters the block forms three registered equality flags, which the surrounding logic places in the idle-time status word.

When a connection drops, READY indications that the departed source never answered are discarded: the READY counter is loaded with the burst count. Buffer credit and the other counts carry over into the next connection. They are lost only when the host pulls its active-low counter-clear input low, when the mode select is set to the reset mode (code 0), or when the chip reset is asserted.

All counters are `CNT_W` bits wide and wrap, so every comparison is made on wrapped values. The chip reset asserts at once and releases through a synchronizer.

Top module: `fc_credit_ctr`

## Requirements
- R1: A cycle with `burst_done` high adds one to `burst_cnt`. `lastb_cnt` also gains one only when `burst_last` is high in that same cycle; otherwise it is unchanged.
- R2: A cycle with `rdy_pulse` high adds one to `ready_cnt`. A cycle with `buf_pulse` high adds one to `buf_cnt`. Pulses to different counters in the same cycle act independently.
- R3: A cycle with `disconnect` high makes `ready_cnt` equal to `burst_cnt` after that edge. This includes any burst completion in the same cycle.
- R4: When `disconnect` and `rdy_pulse` are both high in one cycle, the load takes priority and the READY increment is dropped.
- R5: Every counter wraps modulo 2^`CNT_W` (for example, 2^`CNT_W`+1 increments from zero give 1).
- R6: The flags are `status_flags[0]` = (`ready_cnt` == `burst_cnt`), `status_flags[1]` = (`lastb_cnt` == `buf_cnt`) and `status_flags[2]` = (`ready_cnt` == `buf_cnt`). They are registered and always agree with the counter outputs of the same cycle.
- R7: `clr_cnt_n` low at an edge sets all four counters to zero. This overrides any pulse, load or increment in that cycle.
- R8: `mode_sel` equal to 0 at an edge clears all four counters. Any other mode value leaves the counts untouched. A disconnect never changes `burst_cnt`, `buf_cnt` or `lastb_cnt`.
- R9: `rst_n` low clears the counters at once and sets `status_flags` to 3'b111. After `rst_n` rises, counting is still held for the first clock edge and resumes from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mode_sel | input | 3 | Host mode select; value 0 clears the counters |
| clr_cnt_n | input | 1 | Active-low host request to clear all counters |
| rdy_pulse | input | 1 | One-cycle pulse: a READY was issued |
| buf_pulse | input | 1 | One-cycle pulse: a receive buffer became available |
| burst_done | input | 1 | One-cycle pulse: a burst completed |
| burst_last | input | 1 | Qualifies `burst_done`: the burst closed a packet |
| disconnect | input | 1 | One-cycle pulse: the connection ended |
| ready_cnt | output | CNT_W | READY counter |
| burst_cnt | output | CNT_W | Completed-burst counter |
| buf_cnt | output | CNT_W | Available-buffer counter |
| lastb_cnt | output | CNT_W | Packet-closing burst counter |
| status_flags | output | 3 | Registered equality flags, bit layout as in R6 |

## Verification
The bench builds the block with `CNT_W` = 4, so each counter has only sixteen states and wraparound takes a handful of pulses. It sweeps every pairing of READY count and burst count, with a buffer count derived from the pair. Every flag therefore takes both values, including at the wrap boundary. With counters this narrow, the disconnect-priority cases, the two clear paths and the release of the reset synchronizer can all be checked against plain modular arithmetic.

// File: rtl/fc_credit_pkg.sv
package fc_credit_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_FLAGS = 3;

  localparam logic [MODE_W-1:0] MODE_CLEAR = 3'd0;

  // Fixed bit positions of the flags within status_flags
  typedef enum int {
    FLG_RDY_EQ_BURST = 0,
    FLG_LAST_EQ_BUF  = 1,
    FLG_RDY_EQ_BUF   = 2
  } flag_pos_e;
endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/fc_wrap_counter.sv
module fc_wrap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] STEP = W'(1);

  logic upd_en;

  // Priority: clear, then load, then increment
  always_comb begin
    cnt_nxt = cnt;
    if (clr)       cnt_nxt = '0;
    else if (load) cnt_nxt = load_val;
    else if (inc)  cnt_nxt = cnt + STEP;
    upd_en = clr | load | inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (upd_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/fc_eq_flag.sv
module fc_eq_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lhs_nxt,
  input  logic [W-1:0] rhs_nxt,
  output logic         eq_q
);
  logic eq_d;

  always_comb begin
    eq_d = (lhs_nxt == rhs_nxt);
  end

  // All counters reset to zero, so every flag resets true
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b1;
    else        eq_q <= eq_d;
  end
endmodule

// File: rtl/fc_credit_ctr.sv
module fc_credit_ctr
  import fc_credit_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              clr_cnt_n,
  input  logic              rdy_pulse,
  input  logic              buf_pulse,
  input  logic              burst_done,
  input  logic              burst_last,
  input  logic              disconnect,
  output logic [CNT_W-1:0]  ready_cnt,
  output logic [CNT_W-1:0]  burst_cnt,
  output logic [CNT_W-1:0]  buf_cnt,
  output logic [CNT_W-1:0]  lastb_cnt,
  output logic [NUM_FLAGS-1:0] status_flags
);
  logic rst_q_n;
  logic clr_all;
  logic lastb_inc;

  logic [CNT_W-1:0] ready_nxt;
  logic [CNT_W-1:0] burst_nxt;
  logic [CNT_W-1:0] buf_nxt;
  logic [CNT_W-1:0] lastb_nxt;

  logic [CNT_W-1:0] cmp_lhs [NUM_FLAGS];
  logic [CNT_W-1:0] cmp_rhs [NUM_FLAGS];

  fc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  always_comb begin
    clr_all   = (mode_sel == MODE_CLEAR) || !clr_cnt_n;
    lastb_inc = burst_done & burst_last;
  end

  fc_wrap_counter #(.W(CNT_W)) u_burst (
    .clk (clk), .rst_n (rst_q_n), .clr (clr_all),
    .load (1'b0), .load_val ('0), .inc (burst_done),
    .cnt (burst_cnt), .cnt_nxt (burst_nxt)
  );

  fc_wrap_counter #(.W(CNT_W)) u_lastb (
    .clk (clk), .rst_n (rst_q_n), .clr (clr_all),
    .load (1'b0), .load_val ('0), .inc (lastb_inc),
    .cnt (lastb_cnt), .cnt_nxt (lastb_nxt)
  );

  fc_wrap_counter #(.W(CNT_W)) u_buf (
    .clk (clk), .rst_n (rst_q_n), .clr (clr_all),
    .load (1'b0), .load_val ('0), .inc (buf_pulse),
    .cnt (buf_cnt), .cnt_nxt (buf_nxt)
  );

  // Disconnect resynchronises READY to the burst count, including a
  // burst completing in the same cycle; load outranks the increment.
  fc_wrap_counter #(.W(CNT_W)) u_ready (
    .clk (clk), .rst_n (rst_q_n), .clr (clr_all),
    .load (disconnect), .load_val (burst_nxt), .inc (rdy_pulse),
    .cnt (ready_cnt), .cnt_nxt (ready_nxt)
  );

  always_comb begin
    cmp_lhs[FLG_RDY_EQ_BURST] = ready_nxt;
    cmp_rhs[FLG_RDY_EQ_BURST] = burst_nxt;
    cmp_lhs[FLG_LAST_EQ_BUF]  = lastb_nxt;
    cmp_rhs[FLG_LAST_EQ_BUF]  = buf_nxt;
    cmp_lhs[FLG_RDY_EQ_BUF]   = ready_nxt;
    cmp_rhs[FLG_RDY_EQ_BUF]   = buf_nxt;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    fc_eq_flag #(.W(CNT_W)) u_flag (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .lhs_nxt (cmp_lhs[g]),
      .rhs_nxt (cmp_rhs[g]),
      .eq_q    (status_flags[g])
    );
  end
endmodule

// File: rtl/fc_credit_ctr_chk.sv
module fc_credit_ctr_chk
  import fc_credit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_sel,
  input logic              clr_cnt_n,
  input logic              rdy_pulse,
  input logic              buf_pulse,
  input logic              burst_done,
  input logic              disconnect,
  input logic [CNT_W-1:0]  ready_cnt,
  input logic [CNT_W-1:0]  burst_cnt,
  input logic [CNT_W-1:0]  buf_cnt,
  input logic [CNT_W-1:0]  lastb_cnt,
  input logic [NUM_FLAGS-1:0] status_flags
);
  logic no_clr;
  assign no_clr = clr_cnt_n && (mode_sel != MODE_CLEAR);

  a_r6_flag_rdy_burst: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[0] == (ready_cnt == burst_cnt));

  a_r6_flag_last_buf: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[1] == (lastb_cnt == buf_cnt));

  a_r6_flag_rdy_buf: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[2] == (ready_cnt == buf_cnt));

  a_r1_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && no_clr) |=> burst_cnt == CNT_W'($past(burst_cnt) + 1'b1));

  a_r3_disc_resync: assert property (@(posedge clk) disable iff (!rst_n)
    (disconnect && no_clr) |=> ready_cnt == burst_cnt);

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cnt_n |=> (ready_cnt == '0 && burst_cnt == '0 && buf_cnt == '0 && lastb_cnt == '0));

  a_r8_disc_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (disconnect && !buf_pulse && no_clr) |=> $stable(buf_cnt));

  a_r2_ready_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_pulse && !disconnect && no_clr) |=> $stable(ready_cnt));
endmodule

bind fc_credit_ctr fc_credit_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .mode_sel     (mode_sel),
  .clr_cnt_n    (clr_cnt_n),
  .rdy_pulse    (rdy_pulse),
  .buf_pulse    (buf_pulse),
  .burst_done   (burst_done),
  .disconnect   (disconnect),
  .ready_cnt    (ready_cnt),
  .burst_cnt    (burst_cnt),
  .buf_cnt      (buf_cnt),
  .lastb_cnt    (lastb_cnt),
  .status_flags (status_flags)
);

// File: tb/fc_credit_ctr_test.sv
module fc_credit_ctr_test;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode_sel;
  logic         clr_cnt_n;
  logic         rdy_pulse;
  logic         buf_pulse;
  logic         burst_done;
  logic         burst_last;
  logic         disconnect;
  logic [W-1:0] ready_cnt;
  logic [W-1:0] burst_cnt;
  logic [W-1:0] buf_cnt;
  logic [W-1:0] lastb_cnt;
  logic [2:0]   status_flags;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2ns clk = ~clk;

  fc_credit_ctr #(.CNT_W(W)) uut (
    .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .clr_cnt_n (clr_cnt_n),
    .rdy_pulse (rdy_pulse), .buf_pulse (buf_pulse), .burst_done (burst_done),
    .burst_last (burst_last), .disconnect (disconnect),
    .ready_cnt (ready_cnt), .burst_cnt (burst_cnt), .buf_cnt (buf_cnt),
    .lastb_cnt (lastb_cnt), .status_flags (status_flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    rdy_pulse = 0; buf_pulse = 0; burst_done = 0; burst_last = 0; disconnect = 0;
  endtask

  // Inputs change just after a falling edge; one rising edge passes.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_counts();
    clr_cnt_n = 0; tick(); clr_cnt_n = 1;
  endtask

  function automatic int flags_of(int r, int b, int f, int l);
    return ((r == f) ? 4 : 0) | ((l == f) ? 2 : 0) | ((r == b) ? 1 : 0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_sel = 3'd5; clr_cnt_n = 1; idle();
    tick(); tick(); rdy_pulse = 1; tick(); idle();
    // R9: reset state
    chk("R9 counts in reset", ready_cnt + burst_cnt + buf_cnt + lastb_cnt, 0);
    chk("R9 flags in reset", status_flags, 7);
    // R9: release; first edge after release is still held
    rst_n = 1; rdy_pulse = 1; tick(); idle();
    chk("R9 held after release", ready_cnt, 0);
    tick();
    rdy_pulse = 1; tick(); idle();
    chk("R9 counting resumes", ready_cnt, 1);

    // R6/R2/R1/R5: sweep READY count a and burst count b, buffers (a+b) mod M
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        int c;
        c = (a + b) % M;
        clear_counts();
        for (int i = 0; i < M; i++) begin
          rdy_pulse  = (i < a);
          burst_done = (i < b);
          burst_last = 1'b1;
          buf_pulse  = (i < c);
          tick();
        end
        idle();
        chk("R2 ready sweep", ready_cnt, a);
        chk("R1 burst sweep", burst_cnt, b);
        chk("R2 buffer sweep", buf_cnt, c);
        chk("R1 lastb sweep", lastb_cnt, b);
        chk("R6 flags sweep", status_flags, flags_of(a, b, c, b));
      end
    end

    // R5: wrap
    clear_counts();
    for (int i = 0; i < M + 1; i++) begin rdy_pulse = 1; tick(); end
    idle();
    chk("R5 ready wraps", ready_cnt, 1);
    chk("R6 flags after wrap", status_flags, flags_of(1, 0, 0, 0));

    // R1: burst_last qualifies the last-burst counter
    clear_counts();
    for (int i = 0; i < 5; i++) begin burst_done = 1; burst_last = (i >= 3); tick(); end
    idle();
    chk("R1 burst count", burst_cnt, 5);
    chk("R1 lastb only on last", lastb_cnt, 2);

    // R3: disconnect loads burst count
    clear_counts();
    for (int i = 0; i < 7; i++) begin rdy_pulse = 1; burst_done = (i < 3); burst_last = 1; buf_pulse = (i < 6); tick(); end
    idle();
    disconnect = 1; tick(); idle();
    chk("R3 ready resync", ready_cnt, 3);
    chk("R6 flags after resync", status_flags, flags_of(3, 3, 6, 3));
    chk("R8 buffer survives disconnect", buf_cnt, 6);
    chk("R8 burst survives disconnect", burst_cnt, 3);
    // R3: disconnect with simultaneous burst completion
    disconnect = 1; burst_done = 1; burst_last = 0; tick(); idle();
    chk("R3 resync includes same-cycle burst", ready_cnt, 4);
    chk("R8 lastb survives disconnect", lastb_cnt, 3);
    // R4: load beats READY increment
    disconnect = 1; rdy_pulse = 1; tick(); idle();
    chk("R4 load wins over ready", ready_cnt, 4);

    // R8: non-clear mode keeps counts, mode 0 clears
    mode_sel = 3'd3; tick(); mode_sel = 3'd5;
    chk("R8 other mode keeps buffer", buf_cnt, 6);
    mode_sel = 3'd0; tick(); mode_sel = 3'd5;
    chk("R8 mode 0 clears", ready_cnt + burst_cnt + buf_cnt + lastb_cnt, 0);
    chk("R8 flags after mode 0", status_flags, 7);

    // R7: host clear overrides simultaneous activity
    for (int i = 0; i < 3; i++) begin rdy_pulse = 1; buf_pulse = 1; burst_done = 1; burst_last = 1; tick(); end
    clr_cnt_n = 0; disconnect = 1; tick(); idle(); clr_cnt_n = 1;
    chk("R7 clear ready", ready_cnt, 0);
    chk("R7 clear others", burst_cnt + buf_cnt + lastb_cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule